// File: doc/BRIEF.md
# Sector Group Protection Guard

This block holds the protection state of a flash array of 128 sectors, in which sectors are locked and unlocked in groups of four adjacent sectors. Each group has one stored protect bit. The host sets or clears a group with single-cycle strobes, which stand in for the high-voltage protect and unprotect procedures. A chip-wide strobe clears every group at once. Requests that arrive while a program or erase is running are dropped.

A query port takes a sector number, which is the seven upper bits of the target address. One cycle later the block returns two results: a lock flag, which decides whether a program or erase aimed at that sector may go ahead, and the status byte used by identification reads.

Two pins change the result without touching the stored bits. The write-protect pin, when low, forces one boundary sector to be locked. A build parameter picks whether that is the lowest or the highest sector. The temporary-unprotect input hides all stored group protection while it is high. When it drops, the stored protection applies again exactly as before.

Top module: `sect_guard`

## Requirements
- R1: After synchronous reset every group holds the value of parameter INIT_PROT (default all zero, unprotected), and the query outputs are 0.
- R2: A set strobe protects the group req_sector[6:2], so all four sectors 4g..4g+3 report locked, and neighbouring groups are unchanged.
- R3: A clear strobe unprotects only the group req_sector[6:2].
- R4: A chip-clear strobe unprotects every group. It takes precedence over a set or clear strobe in the same cycle.
- R5: When set and clear strobes arrive in the same cycle without chip-clear, the set wins.
- R6: While busy is high, set, clear and chip-clear strobes have no effect on any stored bit.
- R7: With wp_n low, the boundary sector is locked whatever its stored bit says, including during temporary unprotect. The boundary is sector 0 when WP_HIGH_END=0 (the default) and sector 127 when WP_HIGH_END=1.
- R8: With wp_n high, the boundary sector follows its stored group bit.
- R9: While temp_unprot is high, no sector is locked by its stored bit. When it drops, the stored protection is reported unchanged.
- R10: stat_byte is 8'h01 for a locked sector and 8'h00 for an unlocked one.
- R11: qry_locked and stat_byte are registered. They reflect the qry_sector, wp_n and temp_unprot values and the stored bits present before the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | A program or erase is in progress |
| set_stb | input | 1 | Protect the group of req_sector |
| clr_stb | input | 1 | Unprotect the group of req_sector |
| wipe_stb | input | 1 | Unprotect every group |
| req_sector | input | 7 | Sector selecting the group for set or clear |
| wp_n | input | 1 | Write-protect pin, active low |
| temp_unprot | input | 1 | Temporary-unprotect mode |
| qry_sector | input | 7 | Sector being queried |
| qry_locked | output | 1 | Queried sector is locked |
| stat_byte | output | 8 | Protection status byte of queried sector |

## Verification
The bench targets the group edges: it sets one group and probes the sectors just below and just above it. A design that decodes the group from the wrong address bits would lock the wrong neighbours. It drives set, clear and chip-clear strobes together in one cycle, and drives strobes while busy is high. A wrong priority, or a missing busy gate, then leaves a stored bit different from the bench model. It toggles temporary unprotect over protected groups and checks the boundary sector under a low write-protect pin. A design that overwrote the stored bits, or let temporary unprotect cancel the pin, would report a wrong lock after the mode ends.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_SET  = 2'd1,
    CMD_CLR  = 2'd2,
    CMD_WIPE = 2'd3
  } grp_cmd_e;
endpackage

// File: rtl/sg_cmd_dec.sv
module sg_cmd_dec
  import sg_pkg::*;
(
  input  logic     busy,
  input  logic     set_stb,
  input  logic     clr_stb,
  input  logic     wipe_stb,
  output grp_cmd_e cmd
);
  // priority: busy gate, then chip clear, then set, then clear (R4, R5, R6)
  always_comb begin
    cmd = CMD_NONE;
    if (!busy) begin
      if (wipe_stb)     cmd = CMD_WIPE;
      else if (set_stb) cmd = CMD_SET;
      else if (clr_stb) cmd = CMD_CLR;
    end
  end
endmodule

// File: rtl/sg_grp_store.sv
module sg_grp_store
  import sg_pkg::*;
#(
  parameter int GRP_CNT = 32,
  parameter int GRP_W   = 5,
  parameter logic [GRP_CNT-1:0] INIT_PROT = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  grp_cmd_e           cmd,
  input  logic [GRP_W-1:0]   grp_idx,
  output logic [GRP_CNT-1:0] grp_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q <= INIT_PROT;
    end else begin
      unique case (cmd)
        CMD_WIPE: grp_q <= '0;
        CMD_SET:  grp_q[grp_idx] <= 1'b1;
        CMD_CLR:  grp_q[grp_idx] <= 1'b0;
        default:  grp_q <= grp_q;
      endcase
    end
  end

  // R4: chip clear empties the whole store
  a_r4_wipe_all: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_WIPE) |=> (grp_q == '0));
  // R2: set leaves the addressed group protected
  a_r2_set_group: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SET) |=> grp_q[$past(grp_idx)]);
  // R3: clear leaves the addressed group unprotected
  a_r3_clr_group: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_CLR) |=> !grp_q[$past(grp_idx)]);
endmodule

// File: rtl/sg_prot_eval.sv
module sg_prot_eval #(
  parameter int GRP_CNT     = 32,
  parameter int SEC_W       = 7,
  parameter int GRP_SH      = 2,
  parameter bit WP_HIGH_END = 1'b0
) (
  input  logic [GRP_CNT-1:0] grp_q,
  input  logic [SEC_W-1:0]   sector,
  input  logic               wp_n,
  input  logic               temp_unprot,
  output logic               locked
);
  localparam logic [SEC_W-1:0] BOUND_SEC = WP_HIGH_END ? {SEC_W{1'b1}} : '0;

  logic stored_bit;
  logic pin_force;

  assign stored_bit = grp_q[sector[SEC_W-1:GRP_SH]];
  assign pin_force  = !wp_n && (sector == BOUND_SEC);
  assign locked     = pin_force || (stored_bit && !temp_unprot);
endmodule

// File: rtl/sect_guard.sv
module sect_guard
  import sg_pkg::*;
#(
  parameter int SECTORS     = 128,
  parameter int GROUP_SZ    = 4,
  parameter bit WP_HIGH_END = 1'b0,
  parameter logic [SECTORS/GROUP_SZ-1:0] INIT_PROT = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       busy,
  input  logic                       set_stb,
  input  logic                       clr_stb,
  input  logic                       wipe_stb,
  input  logic [$clog2(SECTORS)-1:0] req_sector,
  input  logic                       wp_n,
  input  logic                       temp_unprot,
  input  logic [$clog2(SECTORS)-1:0] qry_sector,
  output logic                       qry_locked,
  output logic [7:0]                 stat_byte
);
  localparam int SEC_W   = $clog2(SECTORS);
  localparam int GRP_SH  = $clog2(GROUP_SZ);
  localparam int GRP_CNT = SECTORS / GROUP_SZ;
  localparam int GRP_W   = SEC_W - GRP_SH;
  localparam logic [SEC_W-1:0] BOUND_SEC = WP_HIGH_END ? {SEC_W{1'b1}} : '0;

  grp_cmd_e           cmd;
  logic [GRP_CNT-1:0] grp_bits;
  logic               locked_c;

  sg_cmd_dec u_dec (
    .busy     (busy),
    .set_stb  (set_stb),
    .clr_stb  (clr_stb),
    .wipe_stb (wipe_stb),
    .cmd      (cmd)
  );

  sg_grp_store #(
    .GRP_CNT   (GRP_CNT),
    .GRP_W     (GRP_W),
    .INIT_PROT (INIT_PROT)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .grp_idx (req_sector[SEC_W-1:GRP_SH]),
    .grp_q   (grp_bits)
  );

  sg_prot_eval #(
    .GRP_CNT     (GRP_CNT),
    .SEC_W       (SEC_W),
    .GRP_SH      (GRP_SH),
    .WP_HIGH_END (WP_HIGH_END)
  ) u_eval (
    .grp_q       (grp_bits),
    .sector      (qry_sector),
    .wp_n        (wp_n),
    .temp_unprot (temp_unprot),
    .locked      (locked_c)
  );

  // R11: registered query results
  always_ff @(posedge clk) begin
    if (rst) begin
      qry_locked <= 1'b0;
      stat_byte  <= 8'h00;
    end else begin
      qry_locked <= locked_c;
      stat_byte  <= {7'd0, locked_c};
    end
  end

  // R6: busy blocks every change of the stored bits
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(grp_bits));
  // R7: low pin locks the boundary sector
  a_r7_wp_force: assert property (@(posedge clk) disable iff (rst)
    (!wp_n && qry_sector == BOUND_SEC) |=> qry_locked);
  // R9: temporary unprotect leaves only the pin override
  a_r9_temp_clear: assert property (@(posedge clk) disable iff (rst)
    (temp_unprot && (wp_n || qry_sector != BOUND_SEC)) |=> !qry_locked);
  // R10: status byte agrees with lock flag
  a_r10_stat_code: assert property (@(posedge clk) disable iff (rst)
    stat_byte == (qry_locked ? 8'h01 : 8'h00));
endmodule

// File: tb/sect_guard_tb_top.sv
module sect_guard_tb_top;
  localparam int  SECS  = 128;
  localparam int  NGRP  = 32;
  localparam logic [6:0] BOUND = 7'd0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busy = 0, set_stb = 0, clr_stb = 0, wipe_stb = 0;
  logic [6:0] req_sector = '0, qry_sector = '0;
  logic wp_n = 1'b1, temp_unprot = 1'b0;
  logic qry_locked;
  logic [7:0] stat_byte;

  int n_chk = 0, n_bad = 0;
  bit [NGRP-1:0] model = '0;

  always #2.5 clk = ~clk;

  sect_guard dut_i (
    .clk(clk), .rst(rst), .busy(busy), .set_stb(set_stb), .clr_stb(clr_stb),
    .wipe_stb(wipe_stb), .req_sector(req_sector), .wp_n(wp_n),
    .temp_unprot(temp_unprot), .qry_sector(qry_sector),
    .qry_locked(qry_locked), .stat_byte(stat_byte)
  );

  function automatic bit exp_lock(input logic [6:0] s, input bit w, input bit t);
    return ((!w) && s == BOUND) || (model[s[6:2]] && !t);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one strobe cycle, model updated from the requirements
  task automatic op(input bit b, input bit s, input bit c, input bit w, input logic [6:0] sec);
    busy = b; set_stb = s; clr_stb = c; wipe_stb = w; req_sector = sec;
    @(negedge clk);
    if (!b) begin
      if (w) model = '0;
      else if (s) model[sec[6:2]] = 1'b1;
      else if (c) model[sec[6:2]] = 1'b0;
    end
    busy = 0; set_stb = 0; clr_stb = 0; wipe_stb = 0;
  endtask

  task automatic query(input string tag, input logic [6:0] s, input bit w, input bit t);
    bit e;
    qry_sector = s; wp_n = w; temp_unprot = t;
    @(negedge clk);
    e = exp_lock(s, w, t);
    chk(tag, {7'd0, qry_locked}, {7'd0, e});
    chk({tag, "/R10"}, stat_byte, e ? 8'h01 : 8'h00);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 locked", {7'd0, qry_locked}, 8'h00);
    chk("R1 stat", stat_byte, 8'h00);
    query("R1", 7'd127, 1'b1, 1'b0);
    // R2 set group of sector 9 -> 8..11
    op(0, 1, 0, 0, 7'd9);
    query("R2", 7'd8, 1, 0);
    query("R2", 7'd11, 1, 0);
    query("R2", 7'd7, 1, 0);
    query("R2", 7'd12, 1, 0);
    // R3 clear only that group
    op(0, 1, 0, 0, 7'd20);
    op(0, 0, 1, 0, 7'd10);
    query("R3", 7'd9, 1, 0);
    query("R3", 7'd21, 1, 0);
    // R5 set and clear together
    op(0, 1, 1, 0, 7'd40);
    query("R5", 7'd41, 1, 0);
    // R4 chip clear beats set
    op(0, 1, 0, 1, 7'd60);
    query("R4", 7'd61, 1, 0);
    query("R4", 7'd40, 1, 0);
    // R6 busy blocks
    op(0, 1, 0, 0, 7'd100);
    op(1, 0, 0, 1, 7'd0);
    op(1, 1, 0, 0, 7'd5);
    op(1, 0, 1, 0, 7'd100);
    query("R6", 7'd100, 1, 0);
    query("R6", 7'd5, 1, 0);
    // R7 / R8 boundary sector
    query("R7", BOUND, 0, 0);
    query("R7", BOUND, 0, 1);
    query("R7", 7'd1, 0, 0);
    query("R8", BOUND, 1, 0);
    op(0, 1, 0, 0, BOUND);
    query("R8", BOUND, 1, 0);
    // R9 temporary unprotect and return
    query("R9", 7'd101, 1, 1);
    query("R9", 7'd2, 1, 1);
    query("R9", 7'd101, 1, 0);
    // R11 one-cycle latency: output still old before the edge
    qry_sector = 7'd50; wp_n = 1; temp_unprot = 0;
    #1;
    chk("R11", {7'd0, qry_locked}, 8'h01);
    @(negedge clk);
    chk("R11", {7'd0, qry_locked}, {7'd0, exp_lock(7'd50, 1, 0)});
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [6:0] rs, qs;
      int k;
      rs = 7'($urandom_range(0, SECS-1));
      qs = 7'($urandom_range(0, SECS-1));
      k  = $urandom_range(0, 9);
      op(k == 0, k inside {[1:4]}, k inside {[4:7]}, k == 8, rs);
      query("R2/R3 rand", qs, ($urandom_range(0, 3) != 0), ($urandom_range(0, 4) == 0));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule